// File: doc/BRIEF.md
# Sideband Message Mailbox

This block is a register-mapped mailbox. A host uses it to compose one sideband message and send it to an internal endpoint. The host reaches it through a small configuration-space register port. Each access addresses one dword, and byte enables select which bytes a write changes. The host fills in a destination port and a target offset, the write data, an opcode with a posted flag, and a routing word. The routing word carries byte enables, a base-register select and a function number. Setting the go bit in the status word then launches the message on a valid/ready request port.

While the message is in flight, the go bit reads back as busy. Non-posted messages hold busy until the endpoint returns a response. The 2-bit response code is then stored in the status word. For a successful read-type message, the returned dword is also stored in the data register, where the host can read it back. A posted message releases busy as soon as the request port accepts it. A hide control makes the whole function read as absent, so every register, including the identity word, returns all-ones.

Top module: `sbmb_top`

## Requirements
- R1: After reset, the address, data, status, routing and extended-address registers all read 0, the hide control reads 0 and no request is offered. Dword 0x00 reads {DEV_ID, VEN_ID}.
- R2: Dword index 0x34 (byte 0xD0) holds the port in bits 31:24 and offset bits 15:0, and bits 23:16 read 0. Index 0x35 is data. Index 0x37 holds offset bits above 15. Index 0x36 bits 31:16 are the routing word, in which bit 11 reads 0. Every byte is written only when its enable is set, and an unmapped index reads 0.
- R3: A status write with byte enable 0 set and data bit 0 at 1, made while idle, launches a request. The request carries the port, offset {ext, low16}, opcode (status 15:8), posted flag (status 7), routing word and data register. From the next cycle the busy bit (status bit 0) reads 1.
- R4: The request stays valid with all its fields unchanged until ready is seen.
- R5: A non-posted request keeps busy at 1 after acceptance. The cycle after a response, busy reads 0 and status bits 2:1 hold the response code (0 success, 1 unsuccessful, 2 powered down, 3 mixed).
- R6: A response with code 0 to opcode 0x00, 0x04 or 0x06 loads the response data into the data register. Other opcodes, or a nonzero code, leave the data register unchanged.
- R7: A posted request clears busy the cycle after acceptance and sets the response code to 0, without waiting for a response.
- R8: While busy, writes to the address, data, extended-address and status/routing dwords are ignored, and a second go launches nothing.
- R9: Writing byte 0xE1 (index 0x38, byte enable 1) bit 0 sets the hide control, and writing it to 0 clears it. While hidden, every read returns all-ones, including 0xFFFF for the identity low half, and all writes except the hide byte are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req | input | 1 | Register access strobe |
| cfg_we | input | 1 | 1 = write, 0 = read |
| cfg_dw_addr | input | 6 | Dword index of the access |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_addr (combinational) |
| sb_req_valid | output | 1 | Request offered |
| sb_req_ready | input | 1 | Request accepted this cycle |
| sb_req_port | output | 8 | Destination port |
| sb_req_offset | output | 16+EXT_W | Target offset |
| sb_req_opcode | output | 8 | Message opcode |
| sb_req_posted | output | 1 | Posted message |
| sb_req_rid | output | 16 | Routing word |
| sb_req_data | output | 32 | Write data of the message |
| sb_rsp_valid | input | 1 | Response present |
| sb_rsp_code | input | 2 | Response code |
| sb_rsp_data | input | 32 | Response read data |

## Verification
The hardest behaviour to reach is the set of register writes that land while a message is in flight. This includes a second go issued during the ready wait or during the response wait. These writes must leave no trace, even after busy falls. The stimulus holds ready low, or delays the response, for a random number of cycles. It fills those windows with random writes to every field and a repeated go. After completion it reads the fields back and watches the request port for a stray launch. Read responses with nonzero codes are mixed in to separate the case where the data register is loaded from the case where it is kept.

// File: rtl/sbmb_pkg.sv
package sbmb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } sb_state_t;

  localparam logic [5:0] IDX_ID   = 6'h00;
  localparam logic [5:0] IDX_ADDR = 6'h34;
  localparam logic [5:0] IDX_DATA = 6'h35;
  localparam logic [5:0] IDX_STAT = 6'h36;
  localparam logic [5:0] IDX_EXT  = 6'h37;
  localparam logic [5:0] IDX_HIDE = 6'h38;

  localparam logic [15:0] RID_MASK = 16'hF7FF;

  function automatic logic op_returns_data(input logic [7:0] op);
    return (op == 8'h00) || (op == 8'h04) || (op == 8'h06);
  endfunction

  function automatic logic [31:0] merge_bytes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) begin
      r[i*8 +: 8] = be[i] ? new_v[i*8 +: 8] : old_v[i*8 +: 8];
    end
    return r;
  endfunction

endpackage

// File: rtl/sbmb_regs.sv
module sbmb_regs
  import sbmb_pkg::*;
#(
  parameter int          EXT_W    = 32,
  parameter logic [15:0] VEN_ID   = 16'hA5C3,
  parameter logic [15:0] DEV_ID   = 16'h0F1E,
  parameter bit          HIDE_RST = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_dw_addr,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  input  logic             busy,
  input  logic             cap_en,
  input  logic [1:0]       cap_code,
  input  logic             cap_data_en,
  input  logic [31:0]      cap_data,
  output logic             go,
  output logic             hidden,
  output logic [7:0]       r_port,
  output logic [15:0]      r_offlo,
  output logic [EXT_W-1:0] r_ext,
  output logic [7:0]       r_opcode,
  output logic             r_posted,
  output logic [15:0]      r_rid,
  output logic [31:0]      r_data
);

  logic [7:0]       port_q,   port_d;
  logic [15:0]      offlo_q,  offlo_d;
  logic [EXT_W-1:0] ext_q,    ext_d;
  logic [31:0]      data_q,   data_d;
  logic [7:0]       op_q,     op_d;
  logic             post_q,   post_d;
  logic [15:0]      rid_q,    rid_d;
  logic [1:0]       code_q,   code_d;
  logic             hide_q,   hide_d;

  logic en_addr, en_data, en_ext, en_stat, en_code, en_hide;
  logic wr_any, wr_free;
  logic sel_addr, sel_data, sel_stat, sel_ext, sel_hide;
  logic [31:0] ext_wide, ext_merged, stat_merged;

  assign sel_addr = (cfg_dw_addr == IDX_ADDR);
  assign sel_data = (cfg_dw_addr == IDX_DATA);
  assign sel_stat = (cfg_dw_addr == IDX_STAT);
  assign sel_ext  = (cfg_dw_addr == IDX_EXT);
  assign sel_hide = (cfg_dw_addr == IDX_HIDE);

  assign wr_any  = cfg_req & cfg_we;
  assign wr_free = wr_any & ~hide_q & ~busy;

  always_comb begin
    ext_wide = '0;
    ext_wide[EXT_W-1:0] = ext_q;
  end

  // next-state logic
  always_comb begin
    en_addr = wr_free & sel_addr;
    port_d  = cfg_be[3] ? cfg_wdata[31:24] : port_q;
    offlo_d = merge_bytes({16'h0, offlo_q}, cfg_wdata, cfg_be) & 32'h0000FFFF;

    en_ext     = wr_free & sel_ext;
    ext_merged = merge_bytes(ext_wide, cfg_wdata, cfg_be);
    ext_d      = ext_merged[EXT_W-1:0];

    en_data = cap_data_en | (wr_free & sel_data);
    data_d  = cap_data_en ? cap_data : merge_bytes(data_q, cfg_wdata, cfg_be);

    en_stat     = wr_free & sel_stat;
    stat_merged = merge_bytes({rid_q, op_q, post_q, 7'h0}, cfg_wdata, cfg_be);
    post_d      = stat_merged[7];
    op_d        = stat_merged[15:8];
    rid_d       = stat_merged[31:16] & RID_MASK;

    en_code = cap_en;
    code_d  = cap_code;

    en_hide = wr_any & sel_hide & cfg_be[1];
    hide_d  = cfg_wdata[8];
  end

  assign go = en_stat & cfg_be[0] & cfg_wdata[0];

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= '0;
      offlo_q <= '0;
      ext_q   <= '0;
      data_q  <= '0;
      op_q    <= '0;
      post_q  <= 1'b0;
      rid_q   <= '0;
      code_q  <= '0;
      hide_q  <= HIDE_RST;
    end else begin
      if (en_addr) begin
        port_q  <= port_d;
        offlo_q <= offlo_d[15:0];
      end
      if (en_ext)  ext_q  <= ext_d;
      if (en_data) data_q <= data_d;
      if (en_stat) begin
        post_q <= post_d;
        op_q   <= op_d;
        rid_q  <= rid_d;
      end
      if (en_code) code_q <= code_d;
      if (en_hide) hide_q <= hide_d;
    end
  end

  // read mux
  always_comb begin
    cfg_rdata = '0;
    if (hide_q) begin
      cfg_rdata = '1;
    end else begin
      unique case (cfg_dw_addr)
        IDX_ID:   cfg_rdata = {DEV_ID, VEN_ID};
        IDX_ADDR: cfg_rdata = {port_q, 8'h00, offlo_q};
        IDX_DATA: cfg_rdata = data_q;
        IDX_STAT: cfg_rdata = {rid_q, op_q, post_q, 4'h0, code_q, busy};
        IDX_EXT:  cfg_rdata = ext_wide;
        IDX_HIDE: cfg_rdata = {23'h0, hide_q, 8'h00};
        default:  cfg_rdata = '0;
      endcase
    end
  end

  assign hidden   = hide_q;
  assign r_port   = port_q;
  assign r_offlo  = offlo_q;
  assign r_ext    = ext_q;
  assign r_opcode = op_q;
  assign r_posted = post_q;
  assign r_rid    = rid_q;
  assign r_data   = data_q;

endmodule

// File: rtl/sbmb_fsm.sv
module sbmb_fsm
  import sbmb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic        posted,
  input  logic [7:0]  opcode,
  input  logic        req_ready,
  input  logic        rsp_valid,
  input  logic [1:0]  rsp_code,
  input  logic [31:0] rsp_data,
  output logic        req_valid,
  output logic        busy,
  output logic        wait_rsp,
  output logic        cap_en,
  output logic [1:0]  cap_code,
  output logic        cap_data_en,
  output logic [31:0] cap_data
);

  sb_state_t st_q, st_d;
  logic      st_en;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (go)        st_d = ST_REQ;
      ST_REQ:  if (req_ready) st_d = posted ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (rsp_valid) st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign req_valid   = (st_q == ST_REQ);
  assign wait_rsp    = (st_q == ST_WAIT);
  assign busy        = (st_q != ST_IDLE);
  assign cap_en      = (req_valid & req_ready & posted) | (wait_rsp & rsp_valid);
  assign cap_code    = wait_rsp ? rsp_code : 2'd0;
  assign cap_data_en = wait_rsp & rsp_valid & (rsp_code == 2'd0) & op_returns_data(opcode);
  assign cap_data    = rsp_data;

endmodule

// File: rtl/sbmb_top.sv
module sbmb_top
  import sbmb_pkg::*;
#(
  parameter int          EXT_W    = 32,
  parameter logic [15:0] VEN_ID   = 16'hA5C3,
  parameter logic [15:0] DEV_ID   = 16'h0F1E,
  parameter bit          HIDE_RST = 1'b0,
  localparam int         OFF_W    = 16 + EXT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_req,
  input  logic             cfg_we,
  input  logic [5:0]       cfg_dw_addr,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic             sb_req_valid,
  input  logic             sb_req_ready,
  output logic [7:0]       sb_req_port,
  output logic [OFF_W-1:0] sb_req_offset,
  output logic [7:0]       sb_req_opcode,
  output logic             sb_req_posted,
  output logic [15:0]      sb_req_rid,
  output logic [31:0]      sb_req_data,
  input  logic             sb_rsp_valid,
  input  logic [1:0]       sb_rsp_code,
  input  logic [31:0]      sb_rsp_data
);

  logic             busy, wait_rsp, hidden, go;
  logic             cap_en, cap_data_en;
  logic [1:0]       cap_code;
  logic [31:0]      cap_data;
  logic [15:0]      r_offlo;
  logic [EXT_W-1:0] r_ext;

  sbmb_regs #(
    .EXT_W(EXT_W), .VEN_ID(VEN_ID), .DEV_ID(DEV_ID), .HIDE_RST(HIDE_RST)
  ) i_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_req(cfg_req), .cfg_we(cfg_we), .cfg_dw_addr(cfg_dw_addr),
    .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .busy(busy), .cap_en(cap_en), .cap_code(cap_code),
    .cap_data_en(cap_data_en), .cap_data(cap_data),
    .go(go), .hidden(hidden),
    .r_port(sb_req_port), .r_offlo(r_offlo), .r_ext(r_ext),
    .r_opcode(sb_req_opcode), .r_posted(sb_req_posted),
    .r_rid(sb_req_rid), .r_data(sb_req_data)
  );

  sbmb_fsm i_fsm (
    .clk(clk), .rst_n(rst_n),
    .go(go), .posted(sb_req_posted), .opcode(sb_req_opcode),
    .req_ready(sb_req_ready), .rsp_valid(sb_rsp_valid),
    .rsp_code(sb_rsp_code), .rsp_data(sb_rsp_data),
    .req_valid(sb_req_valid), .busy(busy), .wait_rsp(wait_rsp),
    .cap_en(cap_en), .cap_code(cap_code),
    .cap_data_en(cap_data_en), .cap_data(cap_data)
  );

  assign sb_req_offset = {r_ext, r_offlo};

endmodule

// File: rtl/sbmb_chk.sv
module sbmb_chk #(
  parameter int OFF_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             wait_rsp,
  input logic             hidden,
  input logic             sb_req_valid,
  input logic             sb_req_ready,
  input logic             sb_req_posted,
  input logic [7:0]       sb_req_opcode,
  input logic [OFF_W-1:0] sb_req_offset,
  input logic             sb_rsp_valid,
  input logic [31:0]      cfg_rdata
);

  // R3: an offered request always coincides with busy
  a_r3_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    sb_req_valid |-> busy);

  // R4: request fields hold until accepted
  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req_valid && !sb_req_ready) |=>
      (sb_req_valid && $stable(sb_req_opcode) && $stable(sb_req_offset) && $stable(sb_req_posted)));

  // R5: a response in the wait phase releases busy
  a_r5_rsp_releases: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_rsp && sb_rsp_valid) |=> !busy);

  // R7: posted acceptance releases busy at once
  a_r7_posted_release: assert property (@(posedge clk) disable iff (!rst_n)
    (sb_req_valid && sb_req_ready && sb_req_posted) |=> !busy);

  // R8: a new request only starts from idle
  a_r8_no_relaunch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sb_req_valid) |-> $past(!busy));

  // R9: hidden function reads all-ones
  a_r9_hidden_ones: assert property (@(posedge clk) disable iff (!rst_n)
    hidden |-> (cfg_rdata == 32'hFFFF_FFFF));

endmodule

bind sbmb_top sbmb_chk #(.OFF_W(OFF_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wait_rsp(wait_rsp), .hidden(hidden),
  .sb_req_valid(sb_req_valid), .sb_req_ready(sb_req_ready),
  .sb_req_posted(sb_req_posted), .sb_req_opcode(sb_req_opcode),
  .sb_req_offset(sb_req_offset), .sb_rsp_valid(sb_rsp_valid),
  .cfg_rdata(cfg_rdata)
);

// File: tb/test_sbmb_top.sv
module test_sbmb_top;

  localparam int          EXT_W = 32;
  localparam logic [15:0] VEN   = 16'hA5C3;
  localparam logic [15:0] DEV   = 16'h0F1E;
  localparam logic [5:0]  A_ID = 6'h00, A_ADR = 6'h34, A_DAT = 6'h35,
                          A_STA = 6'h36, A_EXT = 6'h37, A_HID = 6'h38;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_req, cfg_we;
  logic [5:0] cfg_dw_addr;
  logic [3:0] cfg_be;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic sb_req_valid, sb_req_ready, sb_req_posted;
  logic [7:0] sb_req_port, sb_req_opcode;
  logic [16+EXT_W-1:0] sb_req_offset;
  logic [15:0] sb_req_rid;
  logic [31:0] sb_req_data;
  logic sb_rsp_valid;
  logic [1:0] sb_rsp_code;
  logic [31:0] sb_rsp_data;

  always #5 clk = ~clk;

  sbmb_top i_sbmb_top (
    .clk(clk), .rst_n(rst_n), .cfg_req(cfg_req), .cfg_we(cfg_we),
    .cfg_dw_addr(cfg_dw_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sb_req_valid(sb_req_valid), .sb_req_ready(sb_req_ready),
    .sb_req_port(sb_req_port), .sb_req_offset(sb_req_offset),
    .sb_req_opcode(sb_req_opcode), .sb_req_posted(sb_req_posted),
    .sb_req_rid(sb_req_rid), .sb_req_data(sb_req_data),
    .sb_rsp_valid(sb_rsp_valid), .sb_rsp_code(sb_rsp_code), .sb_rsp_data(sb_rsp_data)
  );

  int nchk = 0, nfail = 0;
  bit finished = 0;

  // shadow model
  logic [7:0]  m_port, m_op;
  logic [15:0] m_offlo, m_rid;
  logic [31:0] m_ext, m_data;
  logic        m_post, m_busy, m_hide;
  logic [1:0]  m_code;

  function automatic logic [31:0] mrg(input logic [31:0] o, input logic [31:0] n,
                                      input logic [3:0] be);
    logic [31:0] r;
    for (int i = 0; i < 4; i++) r[i*8 +: 8] = be[i] ? n[i*8 +: 8] : o[i*8 +: 8];
    return r;
  endfunction

  function automatic logic is_rd(input logic [7:0] op);
    return op == 8'h00 || op == 8'h04 || op == 8'h06;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [5:0] a);
    if (m_hide) return 32'hFFFF_FFFF;
    case (a)
      A_ID:  return {DEV, VEN};
      A_ADR: return {m_port, 8'h00, m_offlo};
      A_DAT: return m_data;
      A_STA: return {m_rid, m_op, m_post, 4'h0, m_code, m_busy};
      A_EXT: return m_ext;
      A_HID: return {23'h0, m_hide, 8'h00};
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] t;
    if (a == A_HID && be[1]) m_hide = d[8];
    else if (!m_hide && !m_busy) begin
      case (a)
        A_ADR: begin
          t = mrg({m_port, 8'h00, m_offlo}, d, be);
          m_port = t[31:24]; m_offlo = t[15:0];
        end
        A_DAT: m_data = mrg(m_data, d, be);
        A_EXT: m_ext  = mrg(m_ext, d, be);
        A_STA: begin
          t = mrg({m_rid, m_op, m_post, 7'h0}, d, be);
          m_post = t[7]; m_op = t[15:8]; m_rid = t[31:16] & 16'hF7FF;
          if (be[0] && d[0]) m_busy = 1'b1;
        end
        default: ;
      endcase
    end
  endtask

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [3:0] be, input logic [31:0] d);
    cfg_req = 1; cfg_we = 1; cfg_dw_addr = a; cfg_be = be; cfg_wdata = d;
    @(posedge clk); @(negedge clk);
    cfg_req = 0; cfg_we = 0;
    model_wr(a, be, d);
  endtask

  task automatic rd_chk(input string tag, input logic [5:0] a);
    cfg_dw_addr = a; cfg_req = 1; cfg_we = 0;
    #1;
    check(tag, {32'h0, cfg_rdata}, {32'h0, exp_rd(a)});
    cfg_req = 0;
  endtask

  task automatic wait_req(output bit ok);
    int n = 0;
    ok = 1;
    while (!sb_req_valid && n < 20) begin @(negedge clk); n++; end
    if (!sb_req_valid) ok = 0;
  endtask

  task automatic poke();
    wr(A_ADR, 4'hF, $urandom);
    wr(A_DAT, 4'hF, $urandom);
    wr(A_EXT, 4'hF, $urandom);
    wr(A_STA, 4'hF, $urandom | 32'h1);
  endtask

  task automatic txn(input logic [7:0] op, input bit posted, input logic [1:0] code,
                     input int rdy_dly, input int rsp_dly, input bit do_poke);
    logic [31:0] rdat;
    bit ok;
    rdat = $urandom;
    wr(A_ADR, 4'hF, $urandom);
    wr(A_EXT, 4'hF, $urandom);
    wr(A_DAT, 4'hF, $urandom);
    wr(A_STA, 4'hF, {$urandom_range(0, 65535), op, posted, 6'h0, 1'b1});
    rd_chk("R3 status busy after go", A_STA);
    wait_req(ok);
    check("R3 request offered", {63'h0, ok}, 64'h1);
    check("R3 port", {56'h0, sb_req_port}, {56'h0, m_port});
    check("R3 offset", {16'h0, sb_req_offset}, {16'h0, m_ext, m_offlo});
    check("R3 opcode/posted", {55'h0, sb_req_opcode, sb_req_posted}, {55'h0, m_op, m_post});
    check("R3 rid/data", {16'h0, sb_req_rid, sb_req_data}, {16'h0, m_rid, m_data});
    if (do_poke && !posted) poke();
    for (int i = 0; i < rdy_dly; i++) @(negedge clk);
    check("R4 held until ready", {63'h0, sb_req_valid}, 64'h1);
    sb_req_ready = 1; @(posedge clk); @(negedge clk); sb_req_ready = 0;
    if (posted) begin
      m_busy = 0; m_code = 2'd0;
      rd_chk("R7 posted release", A_STA);
    end else begin
      rd_chk("R5 still busy after accept", A_STA);
      if (do_poke) poke();
      for (int i = 0; i < rsp_dly; i++) @(negedge clk);
      sb_rsp_valid = 1; sb_rsp_code = code; sb_rsp_data = rdat;
      @(posedge clk); @(negedge clk);
      sb_rsp_valid = 0;
      m_busy = 0; m_code = code;
      if (code == 2'd0 && is_rd(op)) m_data = rdat;
      rd_chk("R5 status after response", A_STA);
      rd_chk("R6 data after response", A_DAT);
    end
    if (do_poke) begin
      rd_chk("R8 address unchanged", A_ADR);
      rd_chk("R8 ext unchanged", A_EXT);
      @(negedge clk);
      check("R8 no relaunch", {63'h0, sb_req_valid}, 64'h0);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] ops[7] = '{8'h00, 8'h01, 8'h04, 8'h05, 8'h06, 8'h07, 8'h13};
    int unsigned seed;
    seed = $urandom(32'd20517);
    cfg_req = 0; cfg_we = 0; cfg_dw_addr = 0; cfg_be = 0; cfg_wdata = 0;
    sb_req_ready = 0; sb_rsp_valid = 0; sb_rsp_code = 0; sb_rsp_data = 0;
    m_port = 0; m_op = 0; m_offlo = 0; m_rid = 0; m_ext = 0; m_data = 0;
    m_post = 0; m_busy = 0; m_hide = 0; m_code = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd_chk("R1 id", A_ID);
    rd_chk("R1 addr", A_ADR);
    rd_chk("R1 data", A_DAT);
    rd_chk("R1 status", A_STA);
    rd_chk("R1 ext", A_EXT);
    rd_chk("R1 hide", A_HID);
    check("R1 no request", {63'h0, sb_req_valid}, 64'h0);

    // R2 byte enables and layout
    wr(A_ADR, 4'hF, 32'h11223344);
    rd_chk("R2 addr reserved byte", A_ADR);
    wr(A_ADR, 4'b1000, 32'hAB000000);
    rd_chk("R2 addr port byte only", A_ADR);
    wr(A_DAT, 4'b0101, 32'hDEADBEEF);
    rd_chk("R2 data partial", A_DAT);
    wr(A_EXT, 4'b0010, 32'h0000CC00);
    rd_chk("R2 ext partial", A_EXT);
    wr(A_STA, 4'b1100, 32'hFFFF0000);
    rd_chk("R2 rid bit 11 zero", A_STA);
    rd_chk("R2 unmapped reads 0", 6'h10);

    // directed: read success, read failure, write, posted, pokes
    txn(8'h06, 0, 2'd0, 0, 0, 0);
    txn(8'h00, 0, 2'd2, 2, 3, 0);
    txn(8'h07, 0, 2'd0, 1, 1, 0);
    txn(8'h05, 1, 2'd0, 4, 0, 1);
    txn(8'h04, 0, 2'd3, 3, 5, 1);
    txn(8'h13, 0, 2'd1, 0, 2, 1);

    // R9 hide
    wr(A_HID, 4'b0010, 32'h00000100);
    rd_chk("R9 id all-ones", A_ID);
    rd_chk("R9 addr all-ones", A_ADR);
    wr(A_ADR, 4'hF, 32'h55555555);
    wr(A_STA, 4'hF, 32'h00000601);
    @(negedge clk);
    check("R9 go ignored while hidden", {63'h0, sb_req_valid}, 64'h0);
    wr(A_HID, 4'b0010, 32'h0);
    rd_chk("R9 addr kept after reveal", A_ADR);
    rd_chk("R9 status kept after reveal", A_STA);
    rd_chk("R9 id after reveal", A_ID);

    // random mix
    for (int k = 0; k < 40; k++) begin
      txn(ops[$urandom_range(0, 6)], ($urandom_range(0, 3) == 0),
          2'($urandom_range(0, 3)), $urandom_range(0, 4),
          $urandom_range(0, 6), ($urandom_range(0, 2) == 0));
    end

    summary();
    $finish;
  end

endmodule